// File: doc/BRIEF.md
# Frequency Offset Alarm Monitor

This block watches two clock inputs and raises a separate alarm for each one when its frequency drifts too far from a shared reference clock. It counts the reference clock over a fixed measurement gate of 2^`GATE_LOG2` cycles. Over the same window it counts each monitored clock with a free-running counter. That counter runs in the monitored clock's own domain and reaches the reference domain as a Gray-coded value through a two-flop synchronizer.

At every gate boundary the block compares the number of monitored cycles counted in the gate against the nominal value 2^`GATE_LOG2`. The absolute difference is the offset. One input selects the threshold band: a tight band near 9.2 to 16.6 ppm, or a loose band near 40 to 72 ppm. An alarm sets when the offset is above the band's upper count. It clears only when the offset falls below the band's lower count, so the band acts as hysteresis.

A disable input forces both alarms low and suspends measurement. With the default 2^20 gate, the band counts are 9/17 for the tight band and 41/75 for the loose band.

Top module: `freq_offset_mon`

## Requirements
- R1: Each monitored clock has its own alarm output. Both alarms are measured against one reference clock and one shared gate, and a disturbance on one monitored clock does not change the other alarm.
- R2: The offset is |N - 2^GATE_LOG2|, where N is the number of monitored cycles counted over one gate of 2^GATE_LOG2 reference cycles.
- R3: When thr_sel_i is 0, an alarm sets if its offset is greater than HI0_CNT and clears if its offset is less than LO0_CNT.
- R4: When thr_sel_i is 1, an alarm sets if its offset is greater than HI1_CNT and clears if its offset is less than LO1_CNT.
- R5: An offset from LO to HI inclusive, for the selected band, leaves the alarm at its current value.
- R6: An alarm changes value only on the reference edge that ends a gate, or on the edge after the disable input was sampled high.
- R7: After reset, both alarms stay low until two gate ends have passed, which is one complete measurement.
- R8: While fos_off_i is high, both alarms are low from the first reference edge on. Once it returns low, the alarms stay low until one complete new measurement has finished.
- R9: A monitored clock that stops gives an offset of 2^GATE_LOG2 and sets its alarm.
- R10: A monitored clock that runs slow is detected in the same way as one that runs fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; all logic except the monitored counters runs on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_a_clk_i | input | 1 | First monitored clock |
| mon_b_clk_i | input | 1 | Second monitored clock |
| thr_sel_i | input | 1 | Threshold band select: 0 = tight band, 1 = loose band |
| fos_off_i | input | 1 | Disable: forces both alarms low and stops comparison |
| alarm_a_o | output | 1 | Offset alarm for mon_a_clk_i, active high |
| alarm_b_o | output | 1 | Offset alarm for mon_b_clk_i, active high |

## Verification
A wrong previous-count snapshot or a broken Gray transfer shows up as a wrong alarm within two gates of a clean input. A false alarm at zero offset and a missed alarm at large offset are the likely symptoms. A hysteresis fault shows only when the history matters, so the stimulus steps the offset into the middle of a band both from above and from below and checks that the alarm holds. Faults in the disable path or the start-up path show as an alarm that rises before a full measurement has finished. This is checked within a fraction of one gate after reset or after the disable is released.

// File: rtl/fom_gray_cnt.sv
module fom_gray_cnt #(
  parameter int unsigned W = 22
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q, bin_nx;

  assign bin_nx = bin_q + W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/fom_sync.sv
module fom_sync #(
  parameter int unsigned W      = 22,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // gray to binary
  always_comb begin
    for (int i = 0; i < int'(W); i++) bin_o[i] = ^(stg_q[STAGES-1] >> i);
  end
endmodule

// File: rtl/fom_eval.sv
module fom_eval #(
  parameter int unsigned W         = 22,
  parameter int unsigned GATE_LOG2 = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         off_i,
  input  logic         gate_end_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         alarm_o
);
  localparam logic [W-1:0] EXP_CNT = W'(1) << GATE_LOG2;

  logic [W-1:0] prev_q, delta, diff;
  logic         vld_q;

  assign delta = cnt_i - prev_q;
  assign diff  = (delta >= EXP_CNT) ? delta - EXP_CNT : EXP_CNT - delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      vld_q   <= 1'b0;
      alarm_o <= 1'b0;
    end else if (off_i) begin
      vld_q   <= 1'b0;
      alarm_o <= 1'b0;
    end else if (gate_end_i) begin
      prev_q <= cnt_i;
      vld_q  <= 1'b1;
      if (vld_q) begin
        if (diff > hi_i)      alarm_o <= 1'b1;
        else if (diff < lo_i) alarm_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/freq_offset_mon.sv
module freq_offset_mon #(
  parameter int unsigned GATE_LOG2 = 20,
  parameter int unsigned LO0_CNT   = (92  << GATE_LOG2) / 10_000_000,
  parameter int unsigned HI0_CNT   = (166 << GATE_LOG2) / 10_000_000,
  parameter int unsigned LO1_CNT   = (400 << GATE_LOG2) / 10_000_000,
  parameter int unsigned HI1_CNT   = (720 << GATE_LOG2) / 10_000_000
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic mon_a_clk_i,
  input  logic mon_b_clk_i,
  input  logic thr_sel_i,
  input  logic fos_off_i,
  output logic alarm_a_o,
  output logic alarm_b_o
);
  localparam int unsigned CNT_W = GATE_LOG2 + 2;
  localparam int unsigned NCH   = 2;

  logic [GATE_LOG2-1:0] gate_q;
  logic                 gate_end;
  logic [CNT_W-1:0]     lo_cnt, hi_cnt;
  logic [NCH-1:0]       mon_clk, alarm;

  assign mon_clk  = {mon_b_clk_i, mon_a_clk_i};
  assign gate_end = &gate_q;
  assign lo_cnt   = thr_sel_i ? CNT_W'(LO1_CNT) : CNT_W'(LO0_CNT);
  assign hi_cnt   = thr_sel_i ? CNT_W'(HI1_CNT) : CNT_W'(HI0_CNT);

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_q + GATE_LOG2'(1);
  end

  for (genvar ch = 0; ch < int'(NCH); ch++) begin : g_ch
    logic [CNT_W-1:0] gray, cnt_bin;

    fom_gray_cnt #(.W(CNT_W)) u_cnt (
      .clk_i (mon_clk[ch]),
      .rst_ni(rst_ni),
      .gray_o(gray)
    );

    fom_sync #(.W(CNT_W), .STAGES(2)) u_sync (
      .clk_i (ref_clk_i),
      .rst_ni(rst_ni),
      .d_i   (gray),
      .bin_o (cnt_bin)
    );

    fom_eval #(.W(CNT_W), .GATE_LOG2(GATE_LOG2)) u_eval (
      .clk_i     (ref_clk_i),
      .rst_ni    (rst_ni),
      .off_i     (fos_off_i),
      .gate_end_i(gate_end),
      .cnt_i     (cnt_bin),
      .lo_i      (lo_cnt),
      .hi_i      (hi_cnt),
      .alarm_o   (alarm[ch])
    );
  end

  assign alarm_a_o = alarm[0];
  assign alarm_b_o = alarm[1];
endmodule

// File: rtl/fom_chk.sv
module fom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic off_i,
  input logic gate_end_i,
  input logic alarm_a_i,
  input logic alarm_b_i
);
  logic [1:0] meas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         meas_q <= '0;
    else if (off_i)                      meas_q <= '0;
    else if (gate_end_i && meas_q != 2'd2) meas_q <= meas_q + 2'd1;
  end

  // R8
  off_a_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(off_i) |-> !alarm_a_i);
  // R8
  off_b_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(off_i) |-> !alarm_b_i);
  // R6
  a_change_on_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alarm_a_i) |-> ($past(gate_end_i) || $past(off_i)));
  // R6
  b_change_on_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alarm_b_i) |-> ($past(gate_end_i) || $past(off_i)));
  // R7
  a_first_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_q != 2'd2) |-> !alarm_a_i);
  // R7
  b_first_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_q != 2'd2) |-> !alarm_b_i);
endmodule

bind freq_offset_mon fom_chk u_chk (
  .clk_i     (ref_clk_i),
  .rst_ni    (rst_ni),
  .off_i     (fos_off_i),
  .gate_end_i(gate_end),
  .alarm_a_i (alarm_a_o),
  .alarm_b_i (alarm_b_o)
);

// File: tb/sim_freq_offset_mon.sv
`timescale 1ns/1ps
module sim_freq_offset_mon;
  localparam int G     = 8;
  localparam int GATE  = 1 << G;
  localparam int NVEC  = 8;
  // sel, offset a, offset b, expected a, expected b (sequential: history matters)
  localparam int V_SEL [NVEC] = '{0,  0,   0, 0,  1,  1,  1, 0};
  localparam int V_DA  [NVEC] = '{0, 10,   4, 0, 10, 40, 16, 0};
  localparam int V_DB  [NVEC] = '{0,  0, -10, -4, 0, -10, 40, 0};
  localparam int V_EA  [NVEC] = '{0,  1,   1, 0,  0,  1,  1, 0};
  localparam int V_EB  [NVEC] = '{0,  0,   1, 1,  0,  0,  1, 0};

  logic clk = 1'b0, rst_ni = 1'b0, mon_a = 1'b0, mon_b = 1'b0;
  logic sel = 1'b0, off = 1'b0;
  logic alarm_a, alarm_b;
  real  half_a = 4.0, half_b = 4.0;
  bit   stop_a = 1'b0, stop_b = 1'b0;
  int   checks = 0, errors = 0;

  always #4 clk = ~clk;

  initial forever begin
    if (stop_a) #1;
    else begin #(half_a); mon_a = ~mon_a; end
  end
  initial forever begin
    if (stop_b) #1;
    else begin #(half_b); mon_b = ~mon_b; end
  end

  freq_offset_mon #(.GATE_LOG2(G), .LO0_CNT(3), .HI0_CNT(6), .LO1_CNT(12), .HI1_CNT(24)) u0 (
    .ref_clk_i(clk), .rst_ni(rst_ni), .mon_a_clk_i(mon_a), .mon_b_clk_i(mon_b),
    .thr_sel_i(sel), .fos_off_i(off), .alarm_a_o(alarm_a), .alarm_b_o(alarm_b)
  );

  // d extra cycles per gate of GATE reference cycles
  function automatic real half_for(int d);
    return 4.0 * real'(GATE) / real'(GATE + d);
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    half_a = half_for(40);
    wait_cyc(5);
    check(alarm_a, 1'b0, "R7 reset a");
    check(alarm_b, 1'b0, "R7 reset b");
    rst_ni = 1'b1;
    wait_cyc(400);
    check(alarm_a, 1'b0, "R7 low before full measurement");
    wait_cyc(200);
    check(alarm_a, 1'b1, "R3 trip after first measurement");
    check(alarm_b, 1'b0, "R1 b unaffected");

    for (int i = 0; i < NVEC; i++) begin
      sel    = V_SEL[i][0];
      half_a = half_for(V_DA[i]);
      half_b = half_for(V_DB[i]);
      wait_cyc(3 * GATE);
      // R2 R3 R4 R5 R10 table
      check(alarm_a, V_EA[i][0], $sformatf("R2/R3/R4/R5 vec %0d a", i));
      check(alarm_b, V_EB[i][0], $sformatf("R5/R10 vec %0d b", i));
    end

    sel    = 1'b1;
    stop_b = 1'b1;
    wait_cyc(3 * GATE);
    check(alarm_b, 1'b1, "R9 stopped clock");
    check(alarm_a, 1'b0, "R1 a unaffected by stop");

    half_a = half_for(40);
    wait_cyc(3 * GATE);
    check(alarm_a, 1'b1, "R4 loose band trip");
    off = 1'b1;
    wait_cyc(2);
    check(alarm_a, 1'b0, "R8 disable a");
    check(alarm_b, 1'b0, "R8 disable b");
    wait_cyc(3 * GATE);
    check(alarm_a, 1'b0, "R8 frozen a");
    check(alarm_b, 1'b0, "R8 frozen b");
    off = 1'b0;
    wait_cyc(200);
    check(alarm_a, 1'b0, "R8 low after release");
    wait_cyc(600);
    check(alarm_a, 1'b1, "R8 resumes a");
    check(alarm_b, 1'b1, "R9 resumes b");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule